// File: doc/BRIEF.md
# Mode-Banked Register File

This block holds the architectural register state of a 32-bit core that switches register banks by processor mode. Software sees sixteen logical registers, numbered 0 to 15, plus one current status word and, in the privileged exception modes, one saved status word. Behind that view sit thirty general-purpose storage words, one program counter, one current status word and five saved status words. A 5-bit mode input selects which physical words the logical numbers reach.

Two combinational read ports and one clocked write port use a 4-bit logical index. A user-bank override input sends general-register reads and writes to the user-mode copies, so that privileged code can save or restore a task's banked registers. Logical register 15 is the program counter. Writes to it drop the two low bits. Reads of it return the stored address plus a fixed fetch-ahead offset.

Every port is a plain level-sampled control or data pin. A register file accepts an access on every cycle, so no back-pressure applies and there is no valid/ready handshake.

Top module: `banked_regfile`

## Requirements
- R1: While `rst_n` is low, the block resets every general word, the program counter and all five saved status words to zero, and the current status word to `CPSR_RST` (default 0x000000D3). After reset, a read of index 15 returns 8.
- R2: Indices 0 to 7 reach the same physical words in every mode.
- R3: Mode 10001 (fast interrupt) has its own copies of indices 8 to 14. In modes 10010, 10011, 10111 and 11011, indices 8 to 12 reach the user copies.
- R4: Modes 10010 (interrupt), 10011 (supervisor), 10111 (abort) and 11011 (undefined) each have their own private indices 13 and 14.
- R5: Mode 11111 (system) uses exactly the user bank of mode 10000. Any encoding not listed in R3 to R5 also behaves as mode 10000.
- R6: When `user_bank_i` is high, general-register reads and writes on indices 8 to 14 reach the user copies, whatever the mode.
- R7: A write to index 15 stores the data with bits [1:0] cleared. The program counter is shared by all modes.
- R8: A read of index 15 returns the stored program counter plus `PC_AHEAD` (default 8), modulo 2^32.
- R9: Writes take effect at the rising clock edge. A read in the same cycle as a write to the same physical word returns the old value.
- R10: When `cpsr_we_i` is high, `cpsr_o` takes `cpsr_wdata_i` on the next edge. Otherwise `cpsr_o` holds its value.
- R11: Each of modes 10001, 10010, 10011, 10111 and 11011 has its own saved status word, reached through `spsr_wdata_i`/`spsr_rdata_o` with `spsr_ok_o` high. In the user bank modes (R5), `spsr_ok_o` is low, `spsr_rdata_o` reads 0, and `spsr_we_i` changes no saved status word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_i | input | 5 | Current processor mode encoding |
| user_bank_i | input | 1 | Send general accesses to the user bank |
| rd_a_idx_i | input | 4 | Read port A logical index |
| rd_a_data_o | output | 32 | Read port A data |
| rd_b_idx_i | input | 4 | Read port B logical index |
| rd_b_data_o | output | 32 | Read port B data |
| wr_en_i | input | 1 | Write enable for the general/PC write port |
| wr_idx_i | input | 4 | Write port logical index |
| wr_data_i | input | 32 | Write port data |
| cpsr_we_i | input | 1 | Current status write enable |
| cpsr_wdata_i | input | 32 | Current status write data |
| cpsr_o | output | 32 | Current status word |
| spsr_we_i | input | 1 | Saved status write enable for the current mode |
| spsr_wdata_i | input | 32 | Saved status write data |
| spsr_rdata_o | output | 32 | Saved status word of the current mode |
| spsr_ok_o | output | 1 | Current mode owns a saved status word |

## Verification
The bench builds the block with its default parameters: a 32-bit data width, a fetch-ahead offset of 8, and a current-status reset value of 0xD3. This keeps the offset, the low-bit clearing of the program counter and address wrap at the top of the space all visible in 32-bit values. With these widths, each of the 37 physical words can be tagged with a value unique to its mode and index. Reading those tags back from every mode, with the override both off and on, shows any wrong mapping.

// File: rtl/rbf_pkg.sv
package rbf_pkg;

  typedef enum logic [2:0] {
    BK_USR = 3'd0,
    BK_FIQ = 3'd1,
    BK_IRQ = 3'd2,
    BK_SVC = 3'd3,
    BK_ABT = 3'd4,
    BK_UND = 3'd5
  } bank_e;

  localparam logic [4:0] MD_USR = 5'b10000;
  localparam logic [4:0] MD_FIQ = 5'b10001;
  localparam logic [4:0] MD_IRQ = 5'b10010;
  localparam logic [4:0] MD_SVC = 5'b10011;
  localparam logic [4:0] MD_ABT = 5'b10111;
  localparam logic [4:0] MD_UND = 5'b11011;
  localparam logic [4:0] MD_SYS = 5'b11111;

  localparam int IDX_W     = 4;
  localparam int GPR_N     = 30;
  localparam int PHYS_W    = $clog2(GPR_N);
  localparam int SPSR_N    = 5;
  localparam int SPSR_W    = $clog2(SPSR_N);
  localparam int SHARED_N  = 8;
  localparam int FIQ_FIRST = 8;
  localparam int EXC_FIRST = 13;
  localparam int FIQ_BASE  = 15;
  localparam int EXC_BASE  = 22;
  localparam int EXC_PAIR  = 2;
  localparam int PC_IDX    = 15;

endpackage

// File: rtl/rbf_mode_decode.sv
module rbf_mode_decode
  import rbf_pkg::*;
(
  input  logic [4:0]        mode_i,
  output bank_e             bank_o,
  output logic [SPSR_W-1:0] spsr_sel_o,
  output logic              spsr_ok_o
);

  always_comb begin
    unique case (mode_i)
      MD_FIQ:  bank_o = BK_FIQ;
      MD_IRQ:  bank_o = BK_IRQ;
      MD_SVC:  bank_o = BK_SVC;
      MD_ABT:  bank_o = BK_ABT;
      MD_UND:  bank_o = BK_UND;
      default: bank_o = BK_USR;
    endcase
  end

  always_comb begin
    spsr_ok_o  = (bank_o != BK_USR);
    spsr_sel_o = '0;
    if (spsr_ok_o) spsr_sel_o = SPSR_W'(int'(bank_o) - 1);
  end

endmodule

// File: rtl/rbf_index_map.sv
module rbf_index_map
  import rbf_pkg::*;
(
  input  logic [IDX_W-1:0]  idx_i,
  input  bank_e             bank_i,
  output logic              is_pc_o,
  output logic [PHYS_W-1:0] phys_o
);

  always_comb begin
    is_pc_o = (int'(idx_i) == PC_IDX);
    phys_o  = PHYS_W'(idx_i);
    if (int'(idx_i) >= FIQ_FIRST && !is_pc_o) begin
      if (bank_i == BK_FIQ) begin
        phys_o = PHYS_W'(FIQ_BASE + int'(idx_i) - FIQ_FIRST);
      end else if (int'(idx_i) >= EXC_FIRST && bank_i != BK_USR) begin
        phys_o = PHYS_W'(EXC_BASE + EXC_PAIR * (int'(bank_i) - int'(BK_IRQ))
                         + int'(idx_i) - EXC_FIRST);
      end
    end
  end

endmodule

// File: rtl/rbf_status.sv
module rbf_status
  import rbf_pkg::*;
#(
  parameter int                 DATA_W   = 32,
  parameter logic [DATA_W-1:0]  CPSR_RST = 'hD3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpsr_we_i,
  input  logic [DATA_W-1:0] cpsr_wdata_i,
  output logic [DATA_W-1:0] cpsr_o,
  input  logic              spsr_ok_i,
  input  logic [SPSR_W-1:0] spsr_sel_i,
  input  logic              spsr_we_i,
  input  logic [DATA_W-1:0] spsr_wdata_i,
  output logic [DATA_W-1:0] spsr_rdata_o
);

  logic [DATA_W-1:0] cpsr_q;
  logic [DATA_W-1:0] spsr_q [SPSR_N];

  always_ff @(posedge clk) begin
    if (!rst_n)         cpsr_q <= CPSR_RST;
    else if (cpsr_we_i) cpsr_q <= cpsr_wdata_i;
  end

  for (genvar s = 0; s < SPSR_N; s++) begin : g_spsr
    always_ff @(posedge clk) begin
      if (!rst_n)
        spsr_q[s] <= '0;
      else if (spsr_we_i && spsr_ok_i && int'(spsr_sel_i) == s)
        spsr_q[s] <= spsr_wdata_i;
    end
  end

  assign cpsr_o       = cpsr_q;
  assign spsr_rdata_o = spsr_ok_i ? spsr_q[spsr_sel_i] : '0;

endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
  import rbf_pkg::*;
#(
  parameter int                DATA_W   = 32,
  parameter int                PC_AHEAD = 8,
  parameter logic [DATA_W-1:0] CPSR_RST = 'hD3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [4:0]        mode_i,
  input  logic              user_bank_i,
  input  logic [3:0]        rd_a_idx_i,
  output logic [DATA_W-1:0] rd_a_data_o,
  input  logic [3:0]        rd_b_idx_i,
  output logic [DATA_W-1:0] rd_b_data_o,
  input  logic              wr_en_i,
  input  logic [3:0]        wr_idx_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              cpsr_we_i,
  input  logic [DATA_W-1:0] cpsr_wdata_i,
  output logic [DATA_W-1:0] cpsr_o,
  input  logic              spsr_we_i,
  input  logic [DATA_W-1:0] spsr_wdata_i,
  output logic [DATA_W-1:0] spsr_rdata_o,
  output logic              spsr_ok_o
);

  localparam int N_PORTS  = 3;
  localparam int N_RD     = 2;
  localparam int WR_PORT  = 2;
  localparam int ALIGN_W  = 2;

  bank_e             mode_bank;
  bank_e             gpr_bank;
  logic [SPSR_W-1:0] spsr_sel;

  logic [IDX_W-1:0]  port_idx   [N_PORTS];
  logic              port_is_pc [N_PORTS];
  logic [PHYS_W-1:0] port_phys  [N_PORTS];
  logic [DATA_W-1:0] rd_data    [N_RD];

  logic [DATA_W-1:0] gpr_q [GPR_N];
  logic [DATA_W-1:0] pc_q;
  logic [DATA_W-1:0] pc_view;

  rbf_mode_decode u_mode (
    .mode_i     (mode_i),
    .bank_o     (mode_bank),
    .spsr_sel_o (spsr_sel),
    .spsr_ok_o  (spsr_ok_o)
  );

  // The override only retargets general registers; status access follows the mode.
  assign gpr_bank = user_bank_i ? BK_USR : mode_bank;

  assign port_idx[0]       = rd_a_idx_i;
  assign port_idx[1]       = rd_b_idx_i;
  assign port_idx[WR_PORT] = wr_idx_i;

  for (genvar p = 0; p < N_PORTS; p++) begin : g_map
    rbf_index_map u_map (
      .idx_i   (port_idx[p]),
      .bank_i  (gpr_bank),
      .is_pc_o (port_is_pc[p]),
      .phys_o  (port_phys[p])
    );
  end

  for (genvar g = 0; g < GPR_N; g++) begin : g_gpr
    always_ff @(posedge clk) begin
      if (!rst_n)
        gpr_q[g] <= '0;
      else if (wr_en_i && !port_is_pc[WR_PORT] && int'(port_phys[WR_PORT]) == g)
        gpr_q[g] <= wr_data_i;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      pc_q <= '0;
    else if (wr_en_i && port_is_pc[WR_PORT])
      pc_q <= {wr_data_i[DATA_W-1:ALIGN_W], {ALIGN_W{1'b0}}};
  end

  assign pc_view = pc_q + DATA_W'(PC_AHEAD);

  for (genvar r = 0; r < N_RD; r++) begin : g_rd
    assign rd_data[r] = port_is_pc[r] ? pc_view : gpr_q[port_phys[r]];
  end

  assign rd_a_data_o = rd_data[0];
  assign rd_b_data_o = rd_data[1];

  rbf_status #(
    .DATA_W   (DATA_W),
    .CPSR_RST (CPSR_RST)
  ) u_status (
    .clk          (clk),
    .rst_n        (rst_n),
    .cpsr_we_i    (cpsr_we_i),
    .cpsr_wdata_i (cpsr_wdata_i),
    .cpsr_o       (cpsr_o),
    .spsr_ok_i    (spsr_ok_o),
    .spsr_sel_i   (spsr_sel),
    .spsr_we_i    (spsr_we_i),
    .spsr_wdata_i (spsr_wdata_i),
    .spsr_rdata_o (spsr_rdata_o)
  );

endmodule

// File: rtl/banked_regfile_chk.sv
module banked_regfile_chk
  import rbf_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int PC_AHEAD = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [4:0]        mode_i,
  input logic              user_bank_i,
  input logic [3:0]        rd_a_idx_i,
  input logic [DATA_W-1:0] rd_a_data_o,
  input logic [3:0]        rd_b_idx_i,
  input logic [DATA_W-1:0] rd_b_data_o,
  input logic              wr_en_i,
  input logic [3:0]        wr_idx_i,
  input logic [DATA_W-1:0] wr_data_i,
  input logic              cpsr_we_i,
  input logic [DATA_W-1:0] cpsr_wdata_i,
  input logic [DATA_W-1:0] cpsr_o,
  input logic              spsr_we_i,
  input logic [DATA_W-1:0] spsr_wdata_i,
  input logic [DATA_W-1:0] spsr_rdata_o,
  input logic              spsr_ok_o
);

  assert_pc_aligned_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_a_idx_i == 4'd15) |-> (rd_a_data_o[1:0] == 2'b00));

  assert_pc_ahead_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && wr_idx_i == 4'd15) |=>
      ((rd_b_idx_i == 4'd15) ?
        (rd_b_data_o == (($past(wr_data_i) & ~DATA_W'(3)) + DATA_W'(PC_AHEAD))) : 1'b1));

  assert_write_lands_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && wr_idx_i != 4'd15) |=>
      ((rd_a_idx_i == $past(wr_idx_i) && mode_i == $past(mode_i) &&
        user_bank_i == $past(user_bank_i)) ? (rd_a_data_o == $past(wr_data_i)) : 1'b1));

  assert_cpsr_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !cpsr_we_i |=> $stable(cpsr_o));

  assert_cpsr_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cpsr_we_i |=> (cpsr_o == $past(cpsr_wdata_i)));

  assert_spsr_user_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == MD_USR || mode_i == MD_SYS) |-> (!spsr_ok_o && spsr_rdata_o == '0));

  assert_low_shared_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_a_idx_i < 4'd8 && rd_a_idx_i == rd_b_idx_i) |-> (rd_a_data_o == rd_b_data_o));

endmodule

bind banked_regfile banked_regfile_chk #(.DATA_W(DATA_W), .PC_AHEAD(PC_AHEAD)) u_chk (.*);

// File: tb/banked_regfile_bench.sv
`timescale 1ns/100ps
module banked_regfile_bench;

  localparam int W = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [4:0]    mode_i = 5'b10011;
  logic          user_bank_i = 1'b0;
  logic [3:0]    rd_a_idx_i = '0, rd_b_idx_i = '0, wr_idx_i = '0;
  logic [W-1:0]  rd_a_data_o, rd_b_data_o, cpsr_o, spsr_rdata_o;
  logic          wr_en_i = 1'b0, cpsr_we_i = 1'b0, spsr_we_i = 1'b0;
  logic [W-1:0]  wr_data_i = '0, cpsr_wdata_i = '0, spsr_wdata_i = '0;
  logic          spsr_ok_o;

  always #2 clk = ~clk;

  banked_regfile u_banked_regfile (.*);

  int n_cmp = 0;
  int n_bad = 0;

  logic [W-1:0] ref_gpr [30];
  logic [W-1:0] ref_pc;
  logic [W-1:0] ref_cpsr;
  logic [W-1:0] ref_spsr [5];

  logic [4:0] mode_list [9] = '{5'b10000, 5'b10001, 5'b10010, 5'b10011, 5'b10111,
                                5'b11011, 5'b11111, 5'b10100, 5'b00000};

  // bank: 0 user, 1 fast irq, 2 irq, 3 supervisor, 4 abort, 5 undefined
  function automatic int bank_of(logic [4:0] m);
    case (m)
      5'b10001: return 1;
      5'b10010: return 2;
      5'b10011: return 3;
      5'b10111: return 4;
      5'b11011: return 5;
      default:  return 0;
    endcase
  endfunction

  // slot -1 means program counter
  function automatic int slot_of(int bank, int idx);
    if (idx == 15) return -1;
    if (idx < 8) return idx;
    if (bank == 1) return 15 + idx - 8;
    if (idx >= 13 && bank >= 2) return 22 + 2 * (bank - 2) + idx - 13;
    return idx;
  endfunction

  function automatic string tag_of(logic [4:0] m, logic ub, int idx);
    int b = bank_of(m);
    if (idx == 15) return "R8";
    if (idx < 8) return "R2";
    if (ub && b != 0) return "R6";
    if (b == 0 && m != 5'b10000) return "R5";
    if (b == 1) return "R3";
    if (idx >= 13) return "R4";
    return "R3";
  endfunction

  function automatic logic [W-1:0] ref_read(logic [4:0] m, logic ub, int idx);
    int s = slot_of(ub ? 0 : bank_of(m), idx);
    if (s < 0) return ref_pc + W'(8);
    return ref_gpr[s];
  endfunction

  task automatic chk(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cyc(logic [4:0] m, logic ub, logic [3:0] ra, logic [3:0] rb,
                     logic we, logic [3:0] wi, logic [W-1:0] wd,
                     logic cwe, logic [W-1:0] cwd, logic swe, logic [W-1:0] swd);
    int b;
    int ws;
    string ta;
    @(negedge clk);
    mode_i = m; user_bank_i = ub; rd_a_idx_i = ra; rd_b_idx_i = rb;
    wr_en_i = we; wr_idx_i = wi; wr_data_i = wd;
    cpsr_we_i = cwe; cpsr_wdata_i = cwd; spsr_we_i = swe; spsr_wdata_i = swd;
    #1;
    b  = bank_of(m);
    ws = slot_of(ub ? 0 : b, int'(wi));
    ta = tag_of(m, ub, int'(ra));
    if (we && ws >= 0 && ws == slot_of(ub ? 0 : b, int'(ra))) ta = "R9";
    chk(ta, rd_a_data_o, ref_read(m, ub, int'(ra)));
    chk(tag_of(m, ub, int'(rb)), rd_b_data_o, ref_read(m, ub, int'(rb)));
    chk("R10", cpsr_o, ref_cpsr);
    chk("R11", W'(spsr_ok_o), W'(b != 0));
    chk("R11", spsr_rdata_o, (b != 0) ? ref_spsr[b - 1] : '0);
    @(posedge clk);
    if (we) begin
      if (ws < 0) ref_pc = {wd[W-1:2], 2'b00};
      else ref_gpr[ws] = wd;
    end
    if (cwe) ref_cpsr = cwd;
    if (swe && b != 0) ref_spsr[b - 1] = swd;
  endtask

  initial begin
    #(4 * 200000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    foreach (ref_gpr[i]) ref_gpr[i] = '0;
    foreach (ref_spsr[i]) ref_spsr[i] = '0;
    ref_pc = '0;
    ref_cpsr = 32'h0000_00D3;

    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    rd_a_idx_i = 4'd15; rd_b_idx_i = 4'd0;
    #1;
    // R1: reset state
    chk("R1", rd_a_data_o, 32'd8);
    chk("R1", rd_b_data_o, '0);
    chk("R1", cpsr_o, 32'h0000_00D3);
    chk("R1", spsr_rdata_o, '0);

    // Tag every reachable word with a value unique to mode and index.
    for (int mi = 0; mi < 7; mi++)
      for (int ix = 0; ix < 15; ix++)
        cyc(mode_list[mi], 1'b0, 4'(ix), 4'(ix), 1'b1, 4'(ix),
            {8'(mi), 8'(ix), 16'hA5C3}, 1'b0, '0, 1'b1, {16'h5A5A, 16'(mi)});

    // Read every index from every mode, override off then on.
    for (int ub = 0; ub < 2; ub++)
      for (int mi = 0; mi < 9; mi++)
        for (int ix = 0; ix < 16; ix += 2)
          cyc(mode_list[mi], 1'(ub), 4'(ix), 4'(ix + 1), 1'b0, '0, '0, 1'b0, '0, 1'b0, '0);

    // R7/R8: unaligned write to the program counter, read in another mode.
    cyc(5'b10001, 1'b0, 4'd0, 4'd0, 1'b1, 4'd15, 32'h0000_1003, 1'b0, '0, 1'b0, '0);
    cyc(5'b10111, 1'b0, 4'd15, 4'd15, 1'b0, '0, '0, 1'b0, '0, 1'b0, '0);
    chk("R7", rd_a_data_o, 32'h0000_1008);
    // R8: wrap at the top of the address space
    cyc(5'b10000, 1'b0, 4'd0, 4'd0, 1'b1, 4'd15, 32'hFFFF_FFFE, 1'b0, '0, 1'b0, '0);
    cyc(5'b10000, 1'b0, 4'd15, 4'd0, 1'b0, '0, '0, 1'b0, '0, 1'b0, '0);
    chk("R8", rd_a_data_o, 32'h0000_0004);

    // R6: supervisor writes user r13 through the override.
    cyc(5'b10011, 1'b1, 4'd13, 4'd14, 1'b1, 4'd13, 32'hC0DE_0013, 1'b0, '0, 1'b0, '0);
    cyc(5'b10000, 1'b0, 4'd13, 4'd14, 1'b0, '0, '0, 1'b0, '0, 1'b0, '0);
    chk("R6", rd_a_data_o, 32'hC0DE_0013);

    // R9: same-cycle read of the word being written returns the old value.
    cyc(5'b10010, 1'b0, 4'd14, 4'd14, 1'b1, 4'd14, 32'h1234_5678, 1'b0, '0, 1'b0, '0);
    cyc(5'b10010, 1'b0, 4'd14, 4'd14, 1'b0, '0, '0, 1'b0, '0, 1'b0, '0);
    chk("R9", rd_a_data_o, 32'h1234_5678);

    // R11: saved status writes from user and system modes are dropped.
    cyc(5'b10000, 1'b0, 4'd0, 4'd0, 1'b0, '0, '0, 1'b0, '0, 1'b1, 32'hDEAD_0001);
    cyc(5'b11111, 1'b0, 4'd0, 4'd0, 1'b0, '0, '0, 1'b0, '0, 1'b1, 32'hDEAD_0002);
    for (int mi = 1; mi < 6; mi++) begin
      cyc(mode_list[mi], 1'b0, 4'd0, 4'd0, 1'b0, '0, '0, 1'b0, '0, 1'b0, '0);
      chk("R11", spsr_rdata_o, {16'h5A5A, 16'(mi)});
    end

    // R10: status write and hold
    cyc(5'b10011, 1'b0, 4'd0, 4'd0, 1'b0, '0, '0, 1'b1, 32'hF000_001F, 1'b0, '0);
    cyc(5'b10011, 1'b0, 4'd0, 4'd0, 1'b0, '0, '0, 1'b0, '0, 1'b0, '0);
    chk("R10", cpsr_o, 32'hF000_001F);

    // Constrained random traffic, including unknown mode encodings (R5).
    for (int n = 0; n < 4000; n++)
      cyc(mode_list[$urandom_range(8)], ($urandom_range(3) == 0),
          4'($urandom), 4'($urandom), ($urandom_range(1) == 1), 4'($urandom), $urandom,
          ($urandom_range(7) == 0), $urandom, ($urandom_range(3) == 0), $urandom);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule